// File: doc/BRIEF.md
# Prescaled Auto-Reload Update Timer

This block is a bus-mapped 16-bit up-counter. A 16-bit prescaler divides the system clock, and each prescaled tick moves the count up by one. When the count reaches a programmable reload limit, the next tick returns it to zero. That wrap is an update event. It sets a sticky update flag, and it can drive a level interrupt and a one-clock DMA request pulse.

Software can also force an update by writing the event register. This clears the count and the prescaler phase and loads the pending prescaler value. An option in the control register keeps such forced updates from setting the flag or requesting DMA.

The block is programmed through a simple single-cycle register port. Reads are combinational from the address. Writes take effect at the clock edge on which the write enable is high.

Top module: `upd_timer`

## Requirements
- R1: After reset the control, enable, status, prescaler and count registers read 0, the reload register reads 0xFFFF, the counter is stopped, and the interrupt and DMA outputs are low.
- R2: While control bit 0 (run) is 1, the count rises by one every (P+1) clocks, where P is the active prescaler. While run is 0 the count holds.
- R3: On a prescaled tick with the count equal to the reload value, the count becomes 0 and the status flag (bit 0 at offset 0x10) is set at that same edge.
- R4: A value written to the prescaler register (offset 0x28) does not change the counting rate until the next update event loads it.
- R5: Writing 1 to bit 0 at offset 0x14 clears the count and the prescaler phase at that edge and loads the prescaler. The register always reads 0.
- R6: When control bit 2 (overflow-only) is 1, a software-forced update sets no flag and requests no DMA. When it is 0, a forced update does both.
- R7: Writing 0 to status bit 0 clears the flag. Writing 1 leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R8: The interrupt output is high exactly while the flag is set and enable bit 0 (offset 0x0C) is 1.
- R9: When enable bit 8 is 1, every flag-setting update event drives the DMA request high for the single clock after its edge.
- R10: A read of the count register (offset 0x24) returns the count in bits 15..0, a copy of the flag in bit 31, and zeros in bits 30..16.
- R11: The control (0x00), enable (0x0C), prescaler (0x28), reload (0x2C) and count (0x24) registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Update interrupt level |
| dma_req_o | output | 1 | One-clock DMA request pulse |

## Verification
Each register write and each forced update takes effect at the edge that samples the strobe. Their results are therefore checked at the falling edge right after that write. The flag and the DMA pulse of a wrap appear after the edge on which the count turns to zero. The pulse is gone one edge later, so the bench samples both of those falling edges. For counting, the bench counts the rising edges since the run bit was written. It predicts the count as the number of ticks, floor(edges/(P+1)), taken modulo the reload value plus one. All inputs change on falling edges and all reads settle before the next rising edge.

// File: rtl/upd_timer_pkg.sv
package upd_timer_pkg;
    parameter int TMR_W  = 16;
    parameter int ADDR_W = 8;
    parameter int DATA_W = 32;

    localparam int OFF_CTRL = 'h00;
    localparam int OFF_IEN  = 'h0C;
    localparam int OFF_STS  = 'h10;
    localparam int OFF_EVT  = 'h14;
    localparam int OFF_CNT  = 'h24;
    localparam int OFF_PSC  = 'h28;
    localparam int OFF_RLD  = 'h2C;

    typedef struct packed {
        logic ovf_only;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic dma_en;
        logic irq_en;
    } ien_t;

    function automatic logic [DATA_W-1:0] cnt_word(logic flag, logic [TMR_W-1:0] c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[TMR_W-1:0] = c;
        w[DATA_W-1] = flag;
        return w;
    endfunction
endpackage

// File: rtl/upd_timer_core.sv
module upd_timer_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         sw_upd,
    input  logic [W-1:0] rld,
    input  logic [W-1:0] psc_pre,
    input  logic         cnt_ld,
    input  logic [W-1:0] cnt_ld_val,
    output logic [W-1:0] cnt,
    output logic         ovf_evt
);
    logic [W-1:0] psc_cnt;
    logic [W-1:0] psc_act;
    logic [W-1:0] cnt_q;
    logic         tick;
    logic         upd_evt;

    assign tick    = run && (psc_cnt == psc_act);
    assign ovf_evt = tick && (cnt_q == rld);
    assign upd_evt = ovf_evt || sw_upd;
    assign cnt     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_cnt <= '0;
            psc_act <= '0;
            cnt_q   <= '0;
        end else begin
            if (sw_upd) begin
                psc_cnt <= '0;
                cnt_q   <= '0;
            end else begin
                if (run) psc_cnt <= tick ? '0 : psc_cnt + 1'b1;
                if (cnt_ld)    cnt_q <= cnt_ld_val;
                else if (tick) cnt_q <= ovf_evt ? '0 : cnt_q + 1'b1;
            end
            if (upd_evt) psc_act <= psc_pre;
        end
    end

    p_psc_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !upd_evt |=> $stable(psc_act));
    p_evt_zero_r5: assert property (@(posedge clk) disable iff (rst)
        sw_upd |=> (cnt_q == '0 && psc_cnt == '0));
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (ovf_evt && !cnt_ld) |=> cnt_q == '0);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!run && !sw_upd && !cnt_ld) |=> $stable(cnt_q));
endmodule

// File: rtl/upd_timer_regs.sv
module upd_timer_regs
    import upd_timer_pkg::*;
#(
    parameter int W  = TMR_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic [W-1:0]  cnt,
    input  logic          ovf_evt,
    output logic [DW-1:0] rdata,
    output logic          run,
    output logic          sw_upd,
    output logic [W-1:0]  psc_pre,
    output logic [W-1:0]  rld,
    output logic          cnt_ld,
    output logic [W-1:0]  cnt_ld_val,
    output logic          irq,
    output logic          dma_req
);
    ctrl_t ctrl_q;
    ien_t  ien_q;
    logic  flag_q;
    logic  set_flag;
    logic  clr_wr;
    logic  unused_hi;

    assign unused_hi  = ^wdata[DW-1:W];
    assign run        = ctrl_q.run;
    assign sw_upd     = we && (addr == AW'(OFF_EVT)) && wdata[0];
    assign cnt_ld     = we && (addr == AW'(OFF_CNT));
    assign cnt_ld_val = wdata[W-1:0];
    assign set_flag   = ovf_evt || (sw_upd && !ctrl_q.ovf_only);
    assign clr_wr     = we && (addr == AW'(OFF_STS)) && !wdata[0];
    assign irq        = flag_q && ien_q.irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            ien_q   <= '0;
            flag_q  <= 1'b0;
            psc_pre <= '0;
            rld     <= '1;
            dma_req <= 1'b0;
        end else begin
            if (we && addr == AW'(OFF_CTRL)) ctrl_q <= '{ovf_only: wdata[2], run: wdata[0]};
            if (we && addr == AW'(OFF_IEN))  ien_q  <= '{dma_en: wdata[8], irq_en: wdata[0]};
            if (we && addr == AW'(OFF_PSC))  psc_pre <= wdata[W-1:0];
            if (we && addr == AW'(OFF_RLD))  rld     <= wdata[W-1:0];
            if (set_flag)    flag_q <= 1'b1;
            else if (clr_wr) flag_q <= 1'b0;
            dma_req <= set_flag && ien_q.dma_en;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            AW'(OFF_CTRL): begin rdata[0] = ctrl_q.run; rdata[2] = ctrl_q.ovf_only; end
            AW'(OFF_IEN):  begin rdata[0] = ien_q.irq_en; rdata[8] = ien_q.dma_en; end
            AW'(OFF_STS):  rdata[0] = flag_q;
            AW'(OFF_CNT):  rdata = cnt_word(flag_q, cnt);
            AW'(OFF_PSC):  rdata[W-1:0] = psc_pre;
            AW'(OFF_RLD):  rdata[W-1:0] = rld;
            default:       rdata = '0;
        endcase
    end

    p_sts_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !set_flag) |=> !flag_q);
    p_sts_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_wr) |=> flag_q);
    p_dma_flag_r9: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> flag_q);
    p_urs_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (sw_upd && ctrl_q.ovf_only && !ovf_evt && !flag_q) |=> (!flag_q && !dma_req));
endmodule

// File: rtl/upd_timer.sv
module upd_timer
    import upd_timer_pkg::*;
#(
    parameter int W  = TMR_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o,
    output logic          dma_req_o
);
    logic         run, sw_upd, cnt_ld, ovf_evt;
    logic [W-1:0] psc_pre, rld, cnt_ld_val, cnt;

    upd_timer_regs #(.W(W), .AW(AW), .DW(DW)) regs_i (
        .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .cnt(cnt), .ovf_evt(ovf_evt), .rdata(bus_rdata), .run(run),
        .sw_upd(sw_upd), .psc_pre(psc_pre), .rld(rld), .cnt_ld(cnt_ld),
        .cnt_ld_val(cnt_ld_val), .irq(irq_o), .dma_req(dma_req_o)
    );

    upd_timer_core #(.W(W)) core_i (
        .clk(clk), .rst(rst), .run(run), .sw_upd(sw_upd), .rld(rld),
        .psc_pre(psc_pre), .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val),
        .cnt(cnt), .ovf_evt(ovf_evt)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!irq_o && !dma_req_o));
endmodule

// File: tb/upd_timer_tb_top.sv
module upd_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam logic [15:0] VP [NV] = '{16'd0, 16'd1, 16'd3, 16'd0, 16'd0, 16'd2, 16'd0, 16'd1};
    localparam logic [15:0] VA [NV] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'd4, 16'd4, 16'd3, 16'd0, 16'd2};
    localparam int          VM [NV] = '{10, 10, 9, 5, 4, 13, 3, 5};
    localparam logic [15:0] VC [NV] = '{16'd10, 16'd5, 16'd2, 16'd0, 16'd4, 16'd0, 16'd0, 16'd2};
    localparam logic        VF [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, dma_req_o;
    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] r;

    always #(CLK_PERIOD/2) clk = ~clk;

    upd_timer dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .dma_req_o(dma_req_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(8'h00, r); chk("R1 ctrl", r, 32'h0);
        rd(8'h0C, r); chk("R1 ien", r, 32'h0);
        rd(8'h10, r); chk("R1 sts", r, 32'h0);
        rd(8'h24, r); chk("R1 cnt", r, 32'h0);
        rd(8'h28, r); chk("R1 psc", r, 32'h0);
        rd(8'h2C, r); chk("R1 rld", r, 32'h0000FFFF);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        chk("R1 dma", {31'b0, dma_req_o}, 32'h0);
        @(negedge clk);
        rd(8'h24, r); chk("R1 stopped", r, 32'h0);

        // R2 R3 table of counting cases
        for (int i = 0; i < NV; i++) begin
            wr(8'h00, 32'h4);
            wr(8'h10, 32'h0);
            wr(8'h28, {16'h0, VP[i]});
            wr(8'h2C, {16'h0, VA[i]});
            wr(8'h14, 32'h1);
            wr(8'h00, 32'h5);
            repeat (VM[i]) @(negedge clk);
            rd(8'h24, r);
            chk($sformatf("R2 R3 vec%0d count", i), {16'h0, r[15:0]}, {16'h0, VC[i]});
            rd(8'h10, r);
            chk($sformatf("R3 vec%0d flag", i), r, {31'b0, VF[i]});
        end

        // R2 hold when stopped
        wr(8'h00, 32'h4);
        rd(8'h24, r);
        begin
            logic [31:0] held;
            held = r;
            repeat (5) @(negedge clk);
            rd(8'h24, r); chk("R2 hold", r, held);
        end

        // R11 readback
        wr(8'h24, 32'h1234);
        rd(8'h24, r); chk("R11 cnt write", {16'h0, r[15:0]}, 32'h1234);
        wr(8'h0C, 32'h101);
        rd(8'h0C, r); chk("R11 ien", r, 32'h101);
        rd(8'h00, r); chk("R11 ctrl", r, 32'h4);

        // R4 prescaler takes effect only at update
        wr(8'h10, 32'h0);
        wr(8'h0C, 32'h0);
        wr(8'h28, 32'h0);
        wr(8'h2C, 32'hFFFF);
        wr(8'h14, 32'h1);
        wr(8'h00, 32'h5);
        wr(8'h28, 32'h3);
        repeat (4) @(negedge clk);
        rd(8'h24, r); chk("R4 old rate", r, 32'd5);
        wr(8'h14, 32'h1);
        repeat (8) @(negedge clk);
        rd(8'h24, r); chk("R4 new rate", r, 32'd2);
        rd(8'h14, r); chk("R5 reads zero", r, 32'h0);

        // R6 R8 R9 R10 forced update with overflow-only clear
        wr(8'h00, 32'h0);
        wr(8'h10, 32'h0);
        wr(8'h0C, 32'h101);
        wr(8'h14, 32'h1);
        chk("R9 dma pulse sw", {31'b0, dma_req_o}, 32'h1);
        chk("R8 irq on", {31'b0, irq_o}, 32'h1);
        rd(8'h10, r); chk("R6 flag by sw", r, 32'h1);
        rd(8'h24, r); chk("R10 flag copy", r, 32'h80000000);
        @(negedge clk);
        chk("R9 dma one clock", {31'b0, dma_req_o}, 32'h0);
        wr(8'h10, 32'h1);
        rd(8'h10, r); chk("R7 write one keeps", r, 32'h1);
        wr(8'h10, 32'h0);
        rd(8'h10, r); chk("R7 write zero clears", r, 32'h0);
        chk("R8 irq off", {31'b0, irq_o}, 32'h0);
        wr(8'h00, 32'h4);
        wr(8'h14, 32'h1);
        chk("R6 no dma masked", {31'b0, dma_req_o}, 32'h0);
        rd(8'h10, r); chk("R6 no flag masked", r, 32'h0);

        // R8 interrupt masked by enable
        wr(8'h0C, 32'h100);
        wr(8'h00, 32'h0);
        wr(8'h14, 32'h1);
        chk("R8 irq masked", {31'b0, irq_o}, 32'h0);
        rd(8'h10, r); chk("R8 flag set masked", r, 32'h1);

        // R3 R9 overflow DMA timing
        wr(8'h00, 32'h4);
        wr(8'h10, 32'h0);
        wr(8'h2C, 32'h2);
        wr(8'h28, 32'h0);
        wr(8'h14, 32'h1);
        wr(8'h00, 32'h5);
        repeat (2) @(negedge clk);
        chk("R9 no dma early", {31'b0, dma_req_o}, 32'h0);
        rd(8'h24, r); chk("R3 at limit", r, 32'd2);
        @(negedge clk);
        chk("R9 dma at wrap", {31'b0, dma_req_o}, 32'h1);
        rd(8'h24, r); chk("R3 R10 wrapped", r, 32'h80000000);
        @(negedge clk);
        chk("R9 dma drops", {31'b0, dma_req_o}, 32'h0);
        rd(8'h24, r); chk("R3 after wrap", {16'h0, r[15:0]}, 32'd1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule